// File: doc/BRIEF.md
# Four-Level Descriptor Table Walker with Sticky Non-Secure Tracking

This block resolves a virtual address into an output address by reading 64-bit descriptors from memory, one level at a time, through a hierarchy of up to four tables with a 4 KB granule. A requester gives the virtual address, a 48-bit table base, an input-size value and a start level, and says whether the walk belongs to a secure or a non-secure regime. The walker then issues one descriptor read at a time on a simple request/acknowledge port. It ends with the output address and attributes, or with a fault code and the level where the walk stopped.

The walker keeps a one-bit non-secure flag for the whole walk. A secure walk starts with the flag clear. A non-secure walk starts with it set. At every table level the descriptor's non-secure-table bit (bit 63) is OR-ed into the flag, so the walk can drop from secure to non-secure but can never go back. The flag sets the secure attribute of each following read and also the non-secure bit of the final attributes. Only one walk runs at a time.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and both `mem_rd_valid` and `done` are 0.
- R2: The first read address is the base with its low n bits cleared, OR-ed with the level index. Here n = 64 − tsz − 9·(4 − start level). The level index for level L is va shifted right by 9·(4 − L), masked to bits [11:3]. Every read address has bits [2:0] at zero.
- R3: The first read's `mem_rd_secure` equals `req_secure`. This means the non-secure flag starts clear for a secure regime and set for a non-secure one.
- R4: If a descriptor has bits [1:0] = 11 at a level below 3, it is a table. The next read then goes to {desc[47:12], 12'h000} OR-ed with the index of the next level.
- R5: Each table descriptor's bit 63 is OR-ed into a sticky non-secure flag. Every later read carries `mem_rd_secure` equal to the inverse of that flag. Once the flag is set, no later read of the same walk is secure.
- R6: A descriptor with bit 0 clear ends the walk with `fault` = 1, `fault_code` = 1 (translation), and `fault_lvl` = the level it was read at.
- R7: At level 3, a descriptor with bit 1 clear is reserved and gives a translation fault (code 1). At level 0, a block encoding (bits [1:0] = 01) also gives a translation fault (code 1).
- R8: A leaf ends the walk without a fault. A leaf is a block at level 1 or 2 (bits [1:0] = 01) or a page at level 3 (bits [1:0] = 11). `out_pa` is desc[47:k] joined with va[k−1:0], where k is 30, 21 or 12 for levels 1, 2 and 3.
- R9: `out_attr` is desc[11:2] of the leaf, with two changes. Its bit 3 is replaced by the sticky non-secure flag. Its bit 4 is cleared if any table descriptor of the walk had bit 61 set.
- R10: A read that completes with `mem_rd_err` ends the walk with `fault_code` = 2 (external abort) and `fault_lvl` = that level.
- R11: `done` is a one-cycle pulse, in the cycle after the last read completes. While a walk is running, `req_ready` is 0 and `req_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken when `req_ready` is 1) |
| req_ready | output | 1 | Walker idle |
| req_va | input | 64 | Virtual address to translate |
| req_base | input | 48 | Table base of the start level |
| req_tsz | input | 6 | Input-size value (input range is 64 − tsz bits) |
| req_start_lvl | input | 2 | First lookup level, 0 to 3 |
| req_secure | input | 1 | 1 for a secure regime |
| mem_rd_valid | output | 1 | Descriptor read request, held until acknowledged |
| mem_rd_addr | output | 48 | Descriptor address, 8-byte aligned |
| mem_rd_secure | output | 1 | Secure attribute of the read |
| mem_rd_ack | input | 1 | Read completes this cycle |
| mem_rd_data | input | 64 | Descriptor returned with `mem_rd_ack` |
| mem_rd_err | input | 1 | Read failed, sampled with `mem_rd_ack` |
| done | output | 1 | Walk finished (one-cycle pulse) |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 2 | 0 none, 1 translation, 2 external abort |
| fault_lvl | output | 2 | Level of the final descriptor read |
| out_pa | output | 48 | Output address (valid when `done` and not `fault`) |
| out_attr | output | 10 | Leaf attributes with the non-secure bit merged in |

## Verification
The first read request shows up one cycle after a request is taken. Each later read is presented one cycle after the previous acknowledge. The results and `done` follow one cycle after the final acknowledge. The bench drives and samples on falling edges. Its memory responder checks every read address and secure attribute against a queue, at the first falling edge where the read is visible. A monitor pops the expected result when it sees `done`, so each check lands in exactly the cycle its value is due, whatever the memory latency.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int DESC_W     = 64;
  localparam int ATTR_W     = 10;
  localparam int TA_W       = 5;
  localparam int TA_LSB     = 59;
  localparam int ATTR_LSB   = 2;
  localparam int TA_NS_POS  = 4;
  localparam int TA_AP_POS  = 2;
  localparam int AT_NS_POS  = 3;
  localparam int AT_AP_POS  = 4;

  typedef enum logic [1:0] {
    DK_INVALID = 2'd0,
    DK_TABLE   = 2'd1,
    DK_LEAF    = 2'd2
  } dkind_e;

  typedef enum logic [1:0] {
    FC_NONE   = 2'd0,
    FC_XLATE  = 2'd1,
    FC_EXTABT = 2'd2
  } fcode_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } wstate_e;
endpackage

// File: rtl/ptw_index_gen.sv
module ptw_index_gen
  import ptw_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int PA_W     = 48,
  parameter int LVL_BITS = 9,
  parameter int LEVELS   = 4,
  parameter int TSZ_W    = 6,
  parameter int LVL_W    = 2
) (
  input  logic [VA_W-1:0]  va,
  input  logic [PA_W-1:0]  base,
  input  logic [LVL_W-1:0] lvl,
  input  logic [TSZ_W-1:0] tsz,
  input  logic             first,
  output logic [PA_W-1:0]  addr
);
  localparam int IDX_W = LVL_BITS + 3;

  logic [PA_W-1:0] lane [LEVELS];
  logic [PA_W-1:0] low_mask;
  int              clr_bits;
  logic            unused_va;

  assign unused_va = ^va;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lane
    localparam int SH = LVL_BITS * (LEVELS - l);
    assign lane[l] = {{(PA_W-IDX_W){1'b0}}, va[SH+IDX_W-1:SH+3], 3'b000};
  end

  always_comb begin
    clr_bits = VA_W - int'(tsz) - LVL_BITS * (LEVELS - int'(lvl));
    if (!first || clr_bits <= 0) begin
      low_mask = '0;
    end else if (clr_bits >= PA_W) begin
      low_mask = '1;
    end else begin
      low_mask = (PA_W'(1) << clr_bits) - PA_W'(1);
    end
  end

  assign addr = ((base & ~low_mask) | lane[lvl]) & ~PA_W'(7);
endmodule

// File: rtl/ptw_desc_dec.sv
module ptw_desc_dec
  import ptw_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int PA_W     = 48,
  parameter int LVL_BITS = 9,
  parameter int PG_BITS  = 12,
  parameter int LEVELS   = 4,
  parameter int LVL_W    = 2
) (
  input  logic [DESC_W-1:0] desc,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [VA_W-1:0]   va,
  output dkind_e            kind,
  output logic [PA_W-1:0]   next_base,
  output logic [PA_W-1:0]   leaf_pa,
  output logic [ATTR_W-1:0] raw_attr,
  output logic [TA_W-1:0]   tbl_bits
);
  localparam int LAST = LEVELS - 1;

  logic [PA_W-1:0] pa_lane [LEVELS];
  logic            unused_desc;
  logic            unused_va;

  assign unused_desc = ^desc[TA_LSB-1:PA_W];
  assign unused_va   = ^va;

  always_comb begin
    if (!desc[0]) begin
      kind = DK_INVALID;
    end else if (lvl == LVL_W'(LAST)) begin
      kind = desc[1] ? DK_LEAF : DK_INVALID;
    end else if (desc[1]) begin
      kind = DK_TABLE;
    end else if (lvl == '0) begin
      kind = DK_INVALID;
    end else begin
      kind = DK_LEAF;
    end
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_pa
    localparam int OFS = PG_BITS + LVL_BITS * (LAST - l);
    assign pa_lane[l] = {desc[PA_W-1:OFS], va[OFS-1:0]};
  end

  assign next_base = {desc[PA_W-1:PG_BITS], {PG_BITS{1'b0}}};
  assign leaf_pa   = pa_lane[lvl];
  assign raw_attr  = desc[ATTR_LSB+ATTR_W-1:ATTR_LSB];
  assign tbl_bits  = desc[TA_LSB+TA_W-1:TA_LSB];
endmodule

// File: rtl/ptw_ns_track.sv
module ptw_ns_track
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_ns,
  input  logic              merge,
  input  logic [TA_W-1:0]   merge_bits,
  input  logic [ATTR_W-1:0] raw_attr,
  output logic              ns_flag,
  output logic              ns_next,
  output logic [ATTR_W-1:0] fin_attr
);
  logic [TA_W-1:0] acc;
  logic            unused_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (start) begin
      acc <= {start_ns, {(TA_W-1){1'b0}}};
    end else if (merge) begin
      acc <= acc | merge_bits;
    end
  end

  assign unused_acc = ^acc;
  assign ns_flag    = acc[TA_NS_POS];
  assign ns_next    = acc[TA_NS_POS] | merge_bits[TA_NS_POS];

  always_comb begin
    fin_attr = raw_attr;
    fin_attr[AT_NS_POS] = acc[TA_NS_POS];
    if (acc[TA_AP_POS]) begin
      fin_attr[AT_AP_POS] = 1'b0;
    end
  end

  // R5
  ns_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ns_flag && !start) |=> ns_flag);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int PA_W     = 48,
  parameter int LVL_BITS = 9,
  parameter int PG_BITS  = 12,
  parameter int LEVELS   = 4,
  parameter int TSZ_W    = 6,
  localparam int LVL_W   = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [PA_W-1:0]   req_base,
  input  logic [TSZ_W-1:0]  req_tsz,
  input  logic [LVL_W-1:0]  req_start_lvl,
  input  logic              req_secure,
  output logic              mem_rd_valid,
  output logic [PA_W-1:0]   mem_rd_addr,
  output logic              mem_rd_secure,
  input  logic              mem_rd_ack,
  input  logic [DESC_W-1:0] mem_rd_data,
  input  logic              mem_rd_err,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_code,
  output logic [LVL_W-1:0]  fault_lvl,
  output logic [PA_W-1:0]   out_pa,
  output logic [ATTR_W-1:0] out_attr
);
  wstate_e          st;
  logic [VA_W-1:0]  va_q;
  logic [LVL_W-1:0] lvl_q;

  logic             idle;
  logic             accept;
  logic             rd_done;
  logic [VA_W-1:0]  gen_va;
  logic [PA_W-1:0]  gen_base;
  logic [LVL_W-1:0] gen_lvl;
  logic [PA_W-1:0]  gen_addr;

  dkind_e            dec_kind;
  logic [PA_W-1:0]   dec_next_base;
  logic [PA_W-1:0]   dec_leaf_pa;
  logic [ATTR_W-1:0] dec_raw_attr;
  logic [TA_W-1:0]   dec_tbl_bits;

  logic              ns_flag;
  logic              ns_next;
  logic [ATTR_W-1:0] fin_attr;

  logic   walk_end;
  logic   go_deeper;
  fcode_e end_code;

  assign idle    = (st == ST_IDLE);
  assign accept  = idle && req_valid;
  assign rd_done = (st == ST_FETCH) && mem_rd_ack;

  assign gen_va   = idle ? req_va        : va_q;
  assign gen_base = idle ? req_base      : dec_next_base;
  assign gen_lvl  = idle ? req_start_lvl : lvl_q + LVL_W'(1);

  ptw_index_gen #(
    .VA_W(VA_W), .PA_W(PA_W), .LVL_BITS(LVL_BITS),
    .LEVELS(LEVELS), .TSZ_W(TSZ_W), .LVL_W(LVL_W)
  ) u_idx (
    .va(gen_va), .base(gen_base), .lvl(gen_lvl),
    .tsz(req_tsz), .first(idle), .addr(gen_addr)
  );

  ptw_desc_dec #(
    .VA_W(VA_W), .PA_W(PA_W), .LVL_BITS(LVL_BITS),
    .PG_BITS(PG_BITS), .LEVELS(LEVELS), .LVL_W(LVL_W)
  ) u_dec (
    .desc(mem_rd_data), .lvl(lvl_q), .va(va_q),
    .kind(dec_kind), .next_base(dec_next_base), .leaf_pa(dec_leaf_pa),
    .raw_attr(dec_raw_attr), .tbl_bits(dec_tbl_bits)
  );

  ptw_ns_track u_ns (
    .clk(clk), .rst(rst),
    .start(accept), .start_ns(~req_secure),
    .merge(go_deeper), .merge_bits(dec_tbl_bits),
    .raw_attr(dec_raw_attr),
    .ns_flag(ns_flag), .ns_next(ns_next), .fin_attr(fin_attr)
  );

  always_comb begin
    walk_end  = 1'b0;
    go_deeper = 1'b0;
    end_code  = FC_NONE;
    if (rd_done) begin
      if (mem_rd_err) begin
        walk_end = 1'b1;
        end_code = FC_EXTABT;
      end else begin
        unique case (dec_kind)
          DK_TABLE: go_deeper = 1'b1;
          DK_LEAF:  walk_end  = 1'b1;
          default: begin
            walk_end = 1'b1;
            end_code = FC_XLATE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      req_ready     <= 1'b1;
      va_q          <= '0;
      lvl_q         <= '0;
      mem_rd_valid  <= 1'b0;
      mem_rd_addr   <= '0;
      mem_rd_secure <= 1'b0;
      done          <= 1'b0;
      fault         <= 1'b0;
      fault_code    <= FC_NONE;
      fault_lvl     <= '0;
      out_pa        <= '0;
      out_attr      <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        va_q          <= req_va;
        lvl_q         <= req_start_lvl;
        mem_rd_addr   <= gen_addr;
        mem_rd_secure <= req_secure;
        mem_rd_valid  <= 1'b1;
        req_ready     <= 1'b0;
        st            <= ST_FETCH;
      end
      if (go_deeper) begin
        mem_rd_addr   <= gen_addr;
        mem_rd_secure <= ~ns_next;
        lvl_q         <= lvl_q + LVL_W'(1);
      end
      if (walk_end) begin
        mem_rd_valid <= 1'b0;
        req_ready    <= 1'b1;
        st           <= ST_IDLE;
        done         <= 1'b1;
        fault        <= (end_code != FC_NONE);
        fault_code   <= end_code;
        fault_lvl    <= lvl_q;
        if (end_code == FC_NONE) begin
          out_pa   <= dec_leaf_pa;
          out_attr <= fin_attr;
        end
      end
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> !req_ready);

  // R2
  desc_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> (mem_rd_addr[2:0] == 3'b000));

  // R5
  fetch_sec_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && $past(mem_rd_valid) && !$past(mem_rd_secure)) |-> !mem_rd_secure);

  // R10
  ext_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && mem_rd_ack && mem_rd_err) |=>
      (done && fault && fault_code == 2'(FC_EXTABT)));
endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [47:0] req_base = '0;
  logic [5:0]  req_tsz = '0;
  logic [1:0]  req_start_lvl = '0;
  logic        req_secure = 1'b0;
  logic        mem_rd_valid;
  logic [47:0] mem_rd_addr;
  logic        mem_rd_secure;
  logic        mem_rd_ack;
  logic [63:0] mem_rd_data;
  logic        mem_rd_err;
  logic        done;
  logic        fault;
  logic [1:0]  fault_code;
  logic [1:0]  fault_lvl;
  logic [47:0] out_pa;
  logic [9:0]  out_attr;

  always #4 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_base(req_base), .req_tsz(req_tsz), .req_start_lvl(req_start_lvl),
    .req_secure(req_secure),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_secure(mem_rd_secure), .mem_rd_ack(mem_rd_ack),
    .mem_rd_data(mem_rd_data), .mem_rd_err(mem_rd_err),
    .done(done), .fault(fault), .fault_code(fault_code),
    .fault_lvl(fault_lvl), .out_pa(out_pa), .out_attr(out_attr)
  );

  typedef struct packed {
    logic [47:0] a;
    logic        s;
  } fetch_t;

  typedef struct packed {
    logic        f;
    logic [1:0]  c;
    logic [1:0]  l;
    logic [47:0] pa;
    logic [9:0]  at;
  } res_t;

  fetch_t      exp_f[$];
  res_t        exp_r[$];
  logic [63:0] mem [logic [47:0]];
  bit          err_at [logic [47:0]];
  int          checks = 0;
  int          fails = 0;
  int          mem_lat = 1;
  string       cur_tag = "R1";

  localparam logic [47:0] T0 = 48'h0000_0010_0000;
  localparam logic [47:0] T1 = 48'h0000_0011_0000;
  localparam logic [47:0] T2 = 48'h0000_0012_0000;
  localparam logic [47:0] T3 = 48'h0000_0013_0000;

  function automatic logic [47:0] slot(input logic [47:0] tb, input logic [63:0] va, input int lv);
    return tb | 48'((va >> (9 * (4 - lv))) & 64'hff8);
  endfunction

  function automatic logic [63:0] tdesc(input logic [47:0] nb, input bit nst, input bit apt);
    logic [63:0] d;
    d = {16'h0, nb} | 64'h3;
    d[63] = nst;
    d[61] = apt;
    return d;
  endfunction

  function automatic logic [63:0] ldesc(input logic [47:0] oa, input logic [9:0] at, input bit pg);
    return {16'h0, oa} | (64'(at) << 2) | (pg ? 64'h3 : 64'h1);
  endfunction

  task automatic expect_walk(input logic [63:0] va, input logic [47:0] base,
                             input int tsz, input int slvl, input bit sec);
    logic [4:0]  ta;
    logic [47:0] a;
    logic [47:0] m;
    logic [63:0] d;
    int          lv;
    int          n;
    int          ofs;
    res_t        r;
    fetch_t      f;
    ta = {~sec, 4'b0};
    lv = slvl;
    n  = 64 - tsz - 9 * (4 - lv);
    a  = (n <= 0) ? base : (base & ~((48'd1 << n) - 48'd1));
    forever begin
      a = (a | 48'((va >> (9 * (4 - lv))) & 64'hff8)) & ~48'd7;
      f.a = a;
      f.s = ~ta[4];
      exp_f.push_back(f);
      r = '0;
      r.l = 2'(lv);
      if (err_at.exists(a)) begin
        r.f = 1'b1; r.c = 2'd2;
        exp_r.push_back(r);
        return;
      end
      d = mem.exists(a) ? mem[a] : 64'd0;
      if (!d[0] || (!d[1] && (lv == 3 || lv == 0))) begin
        r.f = 1'b1; r.c = 2'd1;
        exp_r.push_back(r);
        return;
      end
      if (d[1] && lv < 3) begin
        ta = ta | d[63:59];
        a  = {d[47:12], 12'h000};
        lv = lv + 1;
        continue;
      end
      ofs  = 12 + 9 * (3 - lv);
      m    = (48'd1 << ofs) - 48'd1;
      r.pa = (d[47:0] & ~m) | (va[47:0] & m);
      r.at = d[11:2];
      r.at[3] = ta[4];
      if (ta[2]) r.at[4] = 1'b0;
      exp_r.push_back(r);
      return;
    end
  endtask

  task automatic check_fetch(input logic [47:0] a, input logic s);
    fetch_t e;
    checks++;
    if (exp_f.size() == 0) begin
      fails++;
      $display("FAIL %s: unexpected read addr=%h sec=%0b, expected none", cur_tag, a, s);
    end else begin
      e = exp_f.pop_front();
      if (a !== e.a || s !== e.s) begin
        fails++;
        $display("FAIL %s: read addr=%h sec=%0b, expected addr=%h sec=%0b", cur_tag, a, s, e.a, e.s);
      end
    end
  endtask

  // memory responder: reads checked against the scoreboard as they appear
  initial begin
    bit          pend;
    int          cnt;
    logic [47:0] cur;
    pend = 0; cnt = 0; cur = '0;
    mem_rd_ack = 1'b0; mem_rd_err = 1'b0; mem_rd_data = '0;
    forever begin
      @(negedge clk);
      mem_rd_ack = 1'b0;
      mem_rd_err = 1'b0;
      if (!pend && mem_rd_valid && !rst) begin
        pend = 1; cnt = mem_lat; cur = mem_rd_addr;
        check_fetch(mem_rd_addr, mem_rd_secure);
      end else if (pend && cnt > 0) begin
        cnt--;
      end
      if (pend && cnt == 0) begin
        mem_rd_ack  = 1'b1;
        mem_rd_err  = err_at.exists(cur);
        mem_rd_data = mem.exists(cur) ? mem[cur] : 64'd0;
        pend = 0;
      end
    end
  end

  // result monitor
  initial begin
    res_t e;
    forever begin
      @(negedge clk);
      if (done) begin
        checks++;
        if (exp_r.size() == 0) begin
          fails++;
          $display("FAIL %s: unexpected done fault=%0b, expected none", cur_tag, fault);
        end else begin
          e = exp_r.pop_front();
          if (fault !== e.f || fault_code !== e.c || fault_lvl !== e.l ||
              (!e.f && (out_pa !== e.pa || out_attr !== e.at))) begin
            fails++;
            $display("FAIL %s: fault=%0b code=%0d lvl=%0d pa=%h attr=%h, expected fault=%0b code=%0d lvl=%0d pa=%h attr=%h",
                     cur_tag, fault, fault_code, fault_lvl, out_pa, out_attr,
                     e.f, e.c, e.l, e.pa, e.at);
          end
        end
      end
    end
  end

  task automatic run_walk(input string tag, input logic [63:0] va, input logic [47:0] base,
                          input int tsz, input int lvl, input bit sec, input int lat,
                          input bit poke_busy);
    cur_tag = tag;
    mem_lat = lat;
    expect_walk(va, base, tsz, lvl, sec);
    @(negedge clk);
    req_va = va; req_base = base; req_tsz = 6'(tsz);
    req_start_lvl = 2'(lvl); req_secure = sec; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke_busy) begin
      checks++;
      if (req_ready !== 1'b0) begin
        fails++;
        $display("FAIL R11: req_ready=%0b during walk, expected 0", req_ready);
      end
      req_va = va ^ 64'h0000_0040_0000_0000;
      req_secure = ~sec;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (exp_r.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    mem.delete();
    err_at.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] va;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (req_ready !== 1'b1 || mem_rd_valid !== 1'b0 || done !== 1'b0) begin
      fails++;
      $display("FAIL R1: ready=%0b valid=%0b done=%0b, expected 1 0 0", req_ready, mem_rd_valid, done);
    end
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R8 secure four-level walk to a page, raw NS bit dropped (R9)
    va = 64'h0000_5A5A_C3E7_1234;
    mem[slot(T0, va, 0)] = tdesc(T1, 0, 0);
    mem[slot(T1, va, 1)] = tdesc(T2, 0, 0);
    mem[slot(T2, va, 2)] = tdesc(T3, 0, 0);
    mem[slot(T3, va, 3)] = ldesc(48'h0000_ABCD_E000, 10'h3FF, 1);
    run_walk("R2 R3 R4 R8 R9", va, T0, 16, 0, 1'b1, 1, 1'b0);

    // R5 R9 downgrade at level 1 stays non-secure after a clear bit at level 2
    va = 64'h0000_7123_4567_89AB;
    mem[slot(T0, va, 0)] = tdesc(T1, 0, 0);
    mem[slot(T1, va, 1)] = tdesc(T2, 1, 0);
    mem[slot(T2, va, 2)] = tdesc(T3, 0, 0);
    mem[slot(T3, va, 3)] = ldesc(48'h0000_1111_2000, 10'h000, 1);
    run_walk("R5 R9", va, T0, 16, 0, 1'b1, 2, 1'b0);

    // R3 R5 non-secure regime: every read non-secure
    va = 64'h0000_0FED_CBA9_8765;
    mem[slot(T0, va, 0)] = tdesc(T1, 0, 0);
    mem[slot(T1, va, 1)] = tdesc(T2, 0, 0);
    mem[slot(T2, va, 2)] = tdesc(T3, 0, 0);
    mem[slot(T3, va, 3)] = ldesc(48'h0000_2222_3000, 10'h155, 1);
    run_walk("R3 R5", va, T0, 16, 0, 1'b0, 0, 1'b0);

    // R8 R9 level-1 block after a table with bit 61 set clears attr bit 4
    va = 64'h0000_3333_4444_5555;
    mem[slot(T0, va, 0)] = tdesc(T1, 0, 1);
    mem[slot(T1, va, 1)] = ldesc(48'h0001_4003_F000, 10'h010, 0);
    run_walk("R8 R9", va, T0, 16, 0, 1'b1, 1, 1'b0);

    // R8 level-2 block, start level 1
    va = 64'h0000_0045_6789_ABCD;
    mem[slot(T1, va, 1)] = tdesc(T2, 0, 0);
    mem[slot(T2, va, 2)] = ldesc(48'h0000_8765_4000, 10'h2A8, 0);
    run_walk("R8", va, T1, 25, 1, 1'b1, 0, 1'b0);

    // R6 invalid descriptor at level 2
    va = 64'h0000_1234_5678_9000;
    mem[slot(T0, va, 0)] = tdesc(T1, 0, 0);
    mem[slot(T1, va, 1)] = tdesc(T2, 0, 0);
    mem[slot(T2, va, 2)] = 64'hFFFF_FFFF_FFFF_FFFE;
    run_walk("R6", va, T0, 16, 0, 1'b1, 1, 1'b0);

    // R7 reserved encoding at level 3
    va = 64'h0000_4321_8765_A000;
    mem[slot(T0, va, 0)] = tdesc(T1, 0, 0);
    mem[slot(T1, va, 1)] = tdesc(T2, 0, 0);
    mem[slot(T2, va, 2)] = tdesc(T3, 0, 0);
    mem[slot(T3, va, 3)] = ldesc(48'h0000_5555_6000, 10'h0F0, 0);
    run_walk("R7", va, T0, 16, 0, 1'b1, 1, 1'b0);

    // R7 block encoding at level 0
    va = 64'h0000_6000_0000_0000;
    mem[slot(T0, va, 0)] = ldesc(48'h0000_0000_0000, 10'h001, 0);
    run_walk("R7", va, T0, 16, 0, 1'b1, 1, 1'b0);

    // R10 read error at level 1
    va = 64'h0000_2468_ACE0_1357;
    mem[slot(T0, va, 0)] = tdesc(T1, 1, 0);
    mem[slot(T1, va, 1)] = tdesc(T2, 0, 0);
    err_at[slot(T1, va, 1)] = 1'b1;
    run_walk("R10", va, T0, 16, 0, 1'b1, 2, 1'b0);

    // R2 small start table: tsz 28, start level 1, base low 9 bits cleared
    va = 64'h0000_000A_BCDE_F012;
    mem[slot(48'h0000_0020_0E00, va, 1)] = ldesc(48'h0000_C000_0000, 10'h3C3, 0);
    run_walk("R2", va, 48'h0000_0020_0FC0, 28, 1, 1'b1, 1, 1'b0);

    // R11 request while busy is ignored
    va = 64'h0000_0012_3456_7890;
    mem[slot(T1, va, 1)] = ldesc(48'h0000_4000_0000, 10'h0AA, 0);
    run_walk("R11", va, T1, 25, 1, 1'b1, 3, 1'b1);

    // R11 no stray read or result after the ignored request
    checks++;
    if (exp_f.size() != 0 || mem_rd_valid !== 1'b0 || req_ready !== 1'b1) begin
      fails++;
      $display("FAIL R11: pending=%0d valid=%0b ready=%0b, expected 0 0 1",
               exp_f.size(), mem_rd_valid, req_ready);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule